// File: doc/BRIEF.md
# Sticky Host Status and Interrupt Qualifier

This block keeps the host status word of a memory-card host controller and drives its single interrupt line. Single-cycle event pulses from the command, data and FIFO logic set sticky status bits. Software clears those bits by writing ones to them. Next to the sticky bits, the status word shows a live data flag, which follows the FIFO level directly and is never latched.

A host configuration word sits beside the status word. It holds four interrupt enables and the bus and card mode bits that the rest of the controller uses. The interrupt output is registered. It is the OR of the busy, block and SDIO sticky bits and the live data flag, with each term gated by its own enable. The five error bits show in the status word but never drive the interrupt by themselves.

Top module: `sd_host_status_irq`

## Requirements
- R1: After reset every sticky status bit, every configuration bit and the interrupt output are 0.
- R2: An event pulse sets its status bit on the next clock edge, and the bit stays set after the pulse ends. The event vector maps as follows: index 0 to status bit 3 (FIFO error), 1 to bit 4 (CRC7 error), 2 to bit 5 (CRC16 error), 3 to bit 6 (command timeout), 4 to bit 7 (read/erase/write timeout), 5 to bit 8 (SDIO), 6 to bit 9 (block) and 7 to bit 10 (busy).
- R3: A write to the status word (write address 0) clears each of bits 3 to 10 whose written value is 1. Bits written with 0 keep their value.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: Status bit 0 always reads the present level of the FIFO data flag. It is not latched, and writing 1 to it has no effect.
- R6: The configuration word (write and read address 1) stores bit 0 (release command line), bit 1 (wide internal bus), bit 2 (wide external bus), bit 3 (slow card), bit 4 (data enable), bit 5 (SDIO enable), bit 8 (block enable) and bit 10 (busy enable). All other bits read 0. The configuration output carries the same value.
- R7: The interrupt output is a register. On each clock edge it loads the OR of (busy and bit 10), (block and bit 8), (SDIO and bit 5) and (data flag and bit 4), all taken from the state before that edge. It therefore rises one cycle after the event bit or the enable is set.
- R8: The error bits (3 to 7) never raise the interrupt, even when every enable is set.
- R9: The live data flag raises the interrupt only while data enable bit 4 is set. Once the flag drops, the interrupt falls without any clearing write.
- R10: Status reads return 0 in bits 1, 2 and 11 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 1 | Write select: 0 status, 1 configuration |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | 1 | Read select: 0 status, 1 configuration |
| reg_rdata | output | DATA_W | Read data (combinational) |
| evt_pulse | input | 8 | Event pulses for status bits 3 to 10 |
| fifo_data_flag | input | 1 | Live FIFO data flag |
| cfg_o | output | DATA_W | Configuration word |
| irq | output | 1 | Registered interrupt |

## Verification
The hardest case to reach from the ports is a collision: an event pulse and a clearing write that target the same bit on the same edge. Another is a clearing write that misses a bit which is also pulsing. The stimulus table drives both in a single cycle and sets the expected status word in advance for each row. The one-cycle interrupt latency is checked by sampling the interrupt on the negedge right after an enable or event edge, where it must still be low, and again one cycle later.

// File: rtl/sdst_pkg.sv
package sdst_pkg;
   localparam int STAT_W    = 11;
   localparam int EVT_LO    = 3;
   localparam int N_EVT     = 8;
   localparam int POS_DATA  = 0;
   // event index = status bit - EVT_LO
   localparam int EV_SDIO   = 8  - EVT_LO;
   localparam int EV_BLOCK  = 9  - EVT_LO;
   localparam int EV_BUSY   = 10 - EVT_LO;
   // configuration bit positions
   localparam int CF_DATA_EN  = 4;
   localparam int CF_SDIO_EN  = 5;
   localparam int CF_BLOCK_EN = 8;
   localparam int CF_BUSY_EN  = 10;
   localparam logic [STAT_W-1:0] CFG_MASK = 11'h53F;
   localparam int N_SRC = 4;
endpackage

// File: rtl/sdst_sticky_bank.sv
module sdst_sticky_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q_o[i] <= 1'b0;
         else if (set_i[i]) q_o[i] <= 1'b1;
         else if (clr_i[i]) q_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/sdst_cfg_reg.sv
module sdst_cfg_reg #(
   parameter int             W    = 32,
   parameter logic [W-1:0]   MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q[i] <= 1'b0;
            else if (we) q[i] <= d[i];
         end
      end else begin : g_zero
         assign q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/sdst_irq_qual.sv
module sdst_irq_qual #(
   parameter int N_SRC   = 4,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   input  logic [N_SRC-1:0] en,
   output logic             irq
);
   logic any_src;
   assign any_src = |(src & en);

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= any_src;
      end
   end else begin : g_comb
      assign irq = any_src;
   end
endmodule

// File: rtl/sd_host_status_irq.sv
module sd_host_status_irq
   import sdst_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_waddr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_EVT-1:0]  evt_pulse,
   input  logic              fifo_data_flag,
   output logic [DATA_W-1:0] cfg_o,
   output logic              irq
);
   localparam logic [DATA_W-1:0] CFG_MASK_W = DATA_W'(CFG_MASK);

   if (DATA_W < STAT_W) begin : g_bad_width
      $error("sd_host_status_irq: DATA_W must be at least %0d", STAT_W);
   end

   logic [N_EVT-1:0]  clr_bits;
   logic [N_EVT-1:0]  sticky_q;
   logic [DATA_W-1:0] cfg_q;
   logic [N_SRC-1:0]  irq_src;
   logic [N_SRC-1:0]  irq_en;
   logic              cfg_we;

   assign clr_bits = (reg_wr && !reg_waddr) ? reg_wdata[EVT_LO +: N_EVT] : '0;
   assign cfg_we   = reg_wr && reg_waddr;

   sdst_sticky_bank #(.N(N_EVT)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_pulse),
      .clr_i (clr_bits),
      .q_o   (sticky_q)
   );

   sdst_cfg_reg #(.W(DATA_W), .MASK(CFG_MASK_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .d     (reg_wdata),
      .q     (cfg_q)
   );

   assign irq_src = {sticky_q[EV_BUSY], sticky_q[EV_BLOCK],
                     sticky_q[EV_SDIO], fifo_data_flag};
   assign irq_en  = {cfg_q[CF_BUSY_EN], cfg_q[CF_BLOCK_EN],
                     cfg_q[CF_SDIO_EN], cfg_q[CF_DATA_EN]};

   sdst_irq_qual #(.N_SRC(N_SRC), .IRQ_REG(IRQ_REG)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (irq_src),
      .en    (irq_en),
      .irq   (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_raddr) begin
         reg_rdata = cfg_q;
      end else begin
         reg_rdata[POS_DATA]          = fifo_data_flag;
         reg_rdata[EVT_LO +: N_EVT]   = sticky_q;
      end
   end

   assign cfg_o = cfg_q;
endmodule

// File: rtl/sdst_checker.sv
module sdst_checker
   import sdst_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_EVT-1:0]  evt,
   input logic [N_EVT-1:0]  clr,
   input logic [N_EVT-1:0]  stat,
   input logic              flag,
   input logic [DATA_W-1:0] cfg,
   input logic              irq
);
   localparam logic [DATA_W-1:0] MASK_W = DATA_W'(CFG_MASK);

   logic [N_SRC-1:0] en;
   logic [N_SRC-1:0] live_src;
   assign en       = {cfg[CF_BUSY_EN], cfg[CF_BLOCK_EN], cfg[CF_SDIO_EN], cfg[CF_DATA_EN]};
   assign live_src = {stat[EV_BUSY], stat[EV_BLOCK], stat[EV_SDIO], flag};

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((stat & $past(evt)) == $past(evt))); // R4

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(stat) & ~$past(clr)) & ~stat) == '0)); // R2

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~evt) != '0) |=> ((stat & $past(clr & ~evt)) == '0)); // R3

   AST_NO_ENABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((en == '0) && ($past(en) == '0)) |-> !irq); // R7

   AST_ERRORS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((live_src == '0) && ($past(live_src) == '0)) |-> !irq); // R8

   AST_CFG_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg & ~MASK_W) == '0)); // R6
endmodule

bind sd_host_status_irq sdst_checker #(.DATA_W(DATA_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .evt   (evt_pulse),
   .clr   (clr_bits),
   .stat  (sticky_q),
   .flag  (fifo_data_flag),
   .cfg   (cfg_q),
   .irq   (irq)
);

// File: tb/tb_sd_host_status_irq.sv
module tb_sd_host_status_irq;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_waddr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic          reg_raddr = 1'b0;
   logic [DW-1:0] reg_rdata;
   logic [7:0]    evt_pulse = '0;
   logic          fifo_data_flag = 1'b0;
   logic [DW-1:0] cfg_o;
   logic          irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sd_host_status_irq #(.DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .evt_pulse(evt_pulse), .fifo_data_flag(fifo_data_flag),
      .cfg_o(cfg_o), .irq(irq)
   );

   // {event pulses, clear bits, expected sticky bits 10..3}
   localparam logic [23:0] TBL [12] = '{
      {8'h01, 8'h00, 8'h01},   // R2 set FIFO error
      {8'h80, 8'h00, 8'h81},   // R2 set busy
      {8'h00, 8'h01, 8'h80},   // R3 clear one
      {8'h24, 8'h00, 8'hA4},   // R2 two at once
      {8'h00, 8'h20, 8'h84},   // R3 selective clear
      {8'h04, 8'h04, 8'h84},   // R4 collision
      {8'h40, 8'h84, 8'h40},   // R3 R4 mixed
      {8'h00, 8'hFF, 8'h00},   // R3 clear all
      {8'hFF, 8'h00, 8'hFF},   // R2 all set
      {8'h00, 8'h00, 8'hFF},   // R3 zeros keep
      {8'h10, 8'hFF, 8'h10},   // R4 clear all but pulsing
      {8'h00, 8'h10, 8'h00}    // R3
   };

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic write(input logic addr, input logic [DW-1:0] v, input logic [7:0] ev);
      @(negedge clk);
      reg_wr = 1'b1; reg_waddr = addr; reg_wdata = v; evt_pulse = ev;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
      #1;
   endtask

   task automatic pulse(input logic [7:0] ev);
      @(negedge clk);
      evt_pulse = ev;
      @(negedge clk);
      evt_pulse = '0;
      #1;
   endtask

   task automatic read_stat(output logic [DW-1:0] v);
      reg_raddr = 1'b0; #1; v = reg_rdata;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      read_stat(v);
      chk("R1 status after reset", v, 32'h0);
      chk("R1 cfg after reset", cfg_o, 32'h0);
      chk("R1 irq after reset", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 12; i++) begin
         if (TBL[i][15:8] != 8'h0)
            write(1'b0, {21'h0, TBL[i][15:8], 3'b000}, TBL[i][23:16]);
         else
            pulse(TBL[i][23:16]);
         read_stat(v);
         chk($sformatf("R2/R3/R4 row %0d", i), v, {21'h0, TBL[i][7:0], 3'b000});
      end

      // R6 configuration storage
      write(1'b1, 32'hFFFF_FFFF, 8'h0);
      reg_raddr = 1'b1; #1;
      chk("R6 cfg readback", reg_rdata, 32'h0000_053F);
      chk("R6 cfg output", cfg_o, 32'h0000_053F);
      reg_raddr = 1'b0;

      // R8 errors with every enable set
      pulse(8'h1F);
      @(negedge clk); @(negedge clk);
      chk("R8 errors no irq", {31'h0, irq}, 32'h0);
      write(1'b0, 32'h0000_00F8, 8'h0);

      // R7 block source, enable later
      write(1'b1, 32'h0, 8'h0);
      pulse(8'h40);
      @(negedge clk);
      chk("R7 block masked", {31'h0, irq}, 32'h0);
      write(1'b1, 32'h0000_0100, 8'h0);
      chk("R7 latency after enable", {31'h0, irq}, 32'h0);
      @(negedge clk);
      chk("R7 block irq", {31'h0, irq}, 32'h1);
      write(1'b0, 32'h0000_0200, 8'h0);
      chk("R7 irq one cycle past clear", {31'h0, irq}, 32'h1);
      @(negedge clk);
      chk("R3 irq drops after clear", {31'h0, irq}, 32'h0);

      // R7 busy source
      write(1'b1, 32'h0000_0400, 8'h0);
      pulse(8'h80);
      chk("R7 busy latency", {31'h0, irq}, 32'h0);
      @(negedge clk);
      chk("R7 busy irq", {31'h0, irq}, 32'h1);
      write(1'b0, 32'h0000_0400, 8'h0);
      @(negedge clk);
      chk("R7 busy cleared", {31'h0, irq}, 32'h0);

      // R7 SDIO source
      write(1'b1, 32'h0000_0020, 8'h0);
      pulse(8'h20);
      @(negedge clk);
      chk("R7 sdio irq", {31'h0, irq}, 32'h1);
      write(1'b0, 32'h0000_0100, 8'h0);
      @(negedge clk);

      // R5 / R9 live data flag
      write(1'b1, 32'h0, 8'h0);
      @(negedge clk);
      fifo_data_flag = 1'b1;
      read_stat(v);
      chk("R5 flag visible", v, 32'h1);
      @(negedge clk); @(negedge clk);
      chk("R9 flag masked", {31'h0, irq}, 32'h0);
      write(1'b0, 32'h0000_0001, 8'h0);
      fifo_data_flag = 1'b0;
      read_stat(v);
      chk("R5 flag not latched", v, 32'h0);
      fifo_data_flag = 1'b1;
      write(1'b1, 32'h0000_0010, 8'h0);
      @(negedge clk);
      chk("R9 flag irq", {31'h0, irq}, 32'h1);
      fifo_data_flag = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R9 irq follows flag", {31'h0, irq}, 32'h0);

      // R10 unused status bits
      fifo_data_flag = 1'b1;
      pulse(8'hFF);
      read_stat(v);
      chk("R10 status layout", v, 32'h0000_07F9);

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      fifo_data_flag = 1'b0;
      #1;
      read_stat(v);
      chk("R1 status cleared by reset", v, 32'h0);
      chk("R1 cfg cleared by reset", cfg_o, 32'h0);
      chk("R1 irq cleared by reset", {31'h0, irq}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule